// File: doc/BRIEF.md
# Controller Command Packet Processor

This block takes one packet at a time from the host link as a byte stream and answers it with a reply packet on a return byte stream. The first byte of a packet names its class. Only the controller class is handled here. In that class the second byte is a command code and any further bytes are its arguments. Every command has a fixed argument count. A packet that matches its command's count updates the block's settings and is acknowledged. A packet that does not match is answered with an error packet and changes nothing.

The block also keeps a 32-bit seconds clock counted from 1 January 1904. Its value is a stored offset plus the number of one-second ticks seen since reset. Setting the clock rewrites the offset, so the tick count never has to be reloaded. The settings leave the block as plain outputs: the poll enable, the poll period, the 16-bit poll device mask, and single-cycle power-down and system-reset requests.

Top module: `cmdp_top`

## Requirements
- R1: After reset, poll_en is 0, poll_rate is 20, dev_mask is 0xFFFF, and out_valid, pwrdn_req and rst_req are 0.
- R2: An accepted controller command (class byte 0x01) is answered with 0x01, 0x00, the command code, and then any result bytes.
- R3: An unknown command code in a controller packet is answered with the four bytes 0x02, 0x02, 0x01 and the code.
- R4: A known command with the wrong number of argument bytes is answered with 0x02, 0x05, 0x01 and the code, and changes no setting. This includes a packet longer than six bytes.
- R5: Command 0x01 (poll enable) takes one argument. poll_en becomes 1 if the argument is nonzero and 0 if it is zero.
- R6: Command 0x14 (poll period) takes one argument, which is copied to poll_rate. An argument of zero is answered with the bad-argument error and leaves poll_rate unchanged.
- R7: Command 0x19 (device mask) takes two arguments. dev_mask becomes {first, second}, so the first argument is the high byte. The mask changes on no other cycle.
- R8: Commands 0x0A (power-down) and 0x11 (system reset) take no arguments. On acceptance each raises pwrdn_req or rst_req, respectively, for exactly one cycle. A rejected one raises nothing.
- R9: Commands 0x13 and 0x21 take one argument each, are acknowledged with a three-byte reply, and change no output.
- R10: Command 0x03 (read clock) takes no arguments. It answers with four result bytes, most significant first, equal to INIT_SECONDS plus the number of sec_tick pulses since reset, unless the clock has been written.
- R11: Command 0x09 (write clock) takes four argument bytes, most significant first. After it, the clock reads that value plus the ticks seen since the write.
- R12: A packet whose class byte is not 0x01, or which has fewer than two bytes, gets no reply and changes no setting.
- R13: The first reply byte is valid in the second cycle after the cycle that carried the packet's last byte. The remaining bytes follow on consecutive cycles, and out_last marks only the final byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse each elapsed second |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input packet byte |
| in_last | input | 1 | Marks the final byte of the input packet |
| out_valid | output | 1 | Reply byte present |
| out_data | output | 8 | Reply packet byte |
| out_last | output | 1 | Marks the final reply byte |
| poll_en | output | 1 | Autopoll enable |
| poll_rate | output | 8 | Poll period setting |
| dev_mask | output | 16 | Poll device mask |
| pwrdn_req | output | 1 | Power-down request pulse |
| rst_req | output | 1 | System-reset request pulse |

## Verification
Each command is sent once with its correct argument count and again with a wrong count. Comparing the two replies separates the length check from the decode, and reading the setting outputs afterwards shows that a rejected packet left them unchanged. Zero and nonzero arguments tell apart the enable rule and the zero-period rejection. An asymmetric mask value shows the byte order. The clock is read at its reset value and again after a write followed by three ticks, which separates offset arithmetic from tick counting. Packets with a foreign class byte and over-long packets check the gating that happens before decode.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
    localparam int RX_BYTES  = 6;   // class + command + up to four arguments
    localparam int RSP_BYTES = 7;   // header of three + up to four result bytes

    localparam logic [7:0] CLS_CTRL = 8'h01;
    localparam logic [7:0] CLS_ERR  = 8'h02;

    localparam logic [7:0] ERR_UNKNOWN = 8'h02;
    localparam logic [7:0] ERR_BADARG  = 8'h05;

    localparam logic [7:0] OP_POLL_EN  = 8'h01;
    localparam logic [7:0] OP_CLK_RD   = 8'h03;
    localparam logic [7:0] OP_CLK_WR   = 8'h09;
    localparam logic [7:0] OP_PWRDN    = 8'h0A;
    localparam logic [7:0] OP_SYSRST   = 8'h11;
    localparam logic [7:0] OP_SRV_FLAG = 8'h13;
    localparam logic [7:0] OP_RATE     = 8'h14;
    localparam logic [7:0] OP_MASK     = 8'h19;
    localparam logic [7:0] OP_PWR_MSG  = 8'h21;
endpackage

// File: rtl/cmdp_rx.sv
module cmdp_rx
    import cmdp_pkg::*;
#(
    parameter int N  = RX_BYTES,
    parameter int LW = $clog2(N + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    input  logic                in_last,
    output logic                pkt_valid,
    output logic [LW-1:0]       pkt_len,
    output logic [N-1:0][7:0]   pkt_bytes
);
    localparam logic [LW-1:0] CAP = LW'(N + 1);   // saturated count: "too long"

    typedef struct packed {
        logic [N-1:0][7:0] bytes;
        logic [LW-1:0]     cnt;
        logic [LW-1:0]     len;
        logic              done;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic [LW-1:0] cnt_inc;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        cnt_inc   = (st_q.cnt == CAP) ? CAP : st_q.cnt + LW'(1);
        if (in_valid) begin
            for (int i = 0; i < N; i++) begin
                if (st_q.cnt == LW'(i)) st_d.bytes[i] = in_data;
            end
            if (in_last) begin
                st_d.done = 1'b1;
                st_d.len  = cnt_inc;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pkt_valid = st_q.done;
    assign pkt_len   = st_q.len;
    assign pkt_bytes = st_q.bytes;

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> pkt_len != '0) else $error("empty packet flagged"); // R12
endmodule

// File: rtl/cmdp_exec.sv
module cmdp_exec
    import cmdp_pkg::*;
#(
    parameter int          N            = RX_BYTES,
    parameter int          LW           = $clog2(N + 2),
    parameter int          RB           = RSP_BYTES,
    parameter int          RLW          = $clog2(RB + 1),
    parameter logic [31:0] INIT_SECONDS = 32'd2082844800,
    parameter logic [7:0]  INIT_RATE    = 8'd20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_tick,
    input  logic                pkt_valid,
    input  logic [LW-1:0]       pkt_len,
    input  logic [N-1:0][7:0]   pkt_bytes,
    output logic                rsp_load,
    output logic [RLW-1:0]      rsp_len,
    output logic [RB-1:0][7:0]  rsp_bytes,
    output logic                poll_en,
    output logic [7:0]          poll_rate,
    output logic [15:0]         dev_mask,
    output logic                pwrdn_req,
    output logic                rst_req
);
    typedef struct packed {
        logic        poll_en;
        logic [7:0]  rate;
        logic [15:0] mask;
        logic [31:0] offset;
        logic [31:0] elapsed;
        logic        pd;
        logic        rs;
    } ex_st_t;

    localparam ex_st_t RST = '{poll_en: 1'b0, rate: INIT_RATE, mask: 16'hFFFF,
                               offset: INIT_SECONDS, elapsed: 32'd0,
                               pd: 1'b0, rs: 1'b0};

    ex_st_t st_d, st_q;
    logic [LW-1:0] nargs;
    logic [31:0]   now, wr_val;
    logic [7:0]    op;
    logic          known, ok;

    always_comb begin
        st_d      = st_q;
        st_d.pd   = 1'b0;
        st_d.rs   = 1'b0;
        st_d.elapsed = st_q.elapsed + (sec_tick ? 32'd1 : 32'd0);
        now       = st_q.offset + st_q.elapsed;
        op        = pkt_bytes[1];
        nargs     = pkt_len - LW'(2);
        wr_val    = {pkt_bytes[2], pkt_bytes[3], pkt_bytes[4], pkt_bytes[5]};
        known     = 1'b1;
        ok        = 1'b0;
        rsp_load  = 1'b0;
        rsp_len   = RLW'(3);
        rsp_bytes = '0;
        rsp_bytes[0] = CLS_CTRL;
        rsp_bytes[2] = op;
        if (pkt_valid && pkt_bytes[0] == CLS_CTRL && pkt_len >= LW'(2)) begin
            rsp_load = 1'b1;
            case (op)
                OP_POLL_EN: begin
                    ok = (nargs == LW'(1));
                    if (ok) st_d.poll_en = (pkt_bytes[2] != 8'd0);
                end
                OP_RATE: begin
                    ok = (nargs == LW'(1)) && (pkt_bytes[2] != 8'd0);
                    if (ok) st_d.rate = pkt_bytes[2];
                end
                OP_MASK: begin
                    ok = (nargs == LW'(2));
                    if (ok) st_d.mask = {pkt_bytes[2], pkt_bytes[3]};
                end
                OP_PWRDN: begin
                    ok = (nargs == LW'(0));
                    st_d.pd = ok;
                end
                OP_SYSRST: begin
                    ok = (nargs == LW'(0));
                    st_d.rs = ok;
                end
                OP_SRV_FLAG, OP_PWR_MSG: ok = (nargs == LW'(1));
                OP_CLK_RD: begin
                    ok = (nargs == LW'(0));
                    rsp_bytes[3] = now[31:24];
                    rsp_bytes[4] = now[23:16];
                    rsp_bytes[5] = now[15:8];
                    rsp_bytes[6] = now[7:0];
                    rsp_len      = RLW'(7);
                end
                OP_CLK_WR: begin
                    ok = (nargs == LW'(4));
                    if (ok) st_d.offset = wr_val - st_d.elapsed;
                end
                default: known = 1'b0;
            endcase
            if (!known || !ok) begin
                rsp_bytes[0] = CLS_ERR;
                rsp_bytes[1] = known ? ERR_BADARG : ERR_UNKNOWN;
                rsp_bytes[2] = CLS_CTRL;
                rsp_bytes[3] = op;
                rsp_bytes[4] = 8'd0;
                rsp_bytes[5] = 8'd0;
                rsp_bytes[6] = 8'd0;
                rsp_len      = RLW'(4);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign poll_en   = st_q.poll_en;
    assign poll_rate = st_q.rate;
    assign dev_mask  = st_q.mask;
    assign pwrdn_req = st_q.pd;
    assign rst_req   = st_q.rs;

    AST_PD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_req |=> !pwrdn_req) else $error("power-down held"); // R8
    AST_RS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req) else $error("reset request held"); // R8
    AST_RATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        poll_rate != 8'd0) else $error("zero poll period"); // R6
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> $stable(dev_mask)) else $error("mask moved"); // R7
endmodule

// File: rtl/cmdp_tx.sv
module cmdp_tx
    import cmdp_pkg::*;
#(
    parameter int RB  = RSP_BYTES,
    parameter int RLW = $clog2(RB + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [RLW-1:0]     len,
    input  logic [RB-1:0][7:0] bytes,
    output logic               out_valid,
    output logic [7:0]         out_data,
    output logic               out_last
);
    typedef struct packed {
        logic [RB-1:0][7:0] bytes;
        logic [RLW-1:0]     idx;
        logic [RLW-1:0]     len;
        logic               busy;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.idx == st_q.len - RLW'(1));
        if (load) begin
            st_d.bytes = bytes;
            st_d.len   = len;
            st_d.idx   = '0;
            st_d.busy  = 1'b1;
        end else if (st_q.busy) begin
            if (at_end) st_d.busy = 1'b0;
            else        st_d.idx  = st_q.idx + RLW'(1);
        end
        out_data = 8'd0;
        for (int i = 0; i < RB; i++) begin
            if (st_q.idx == RLW'(i)) out_data = st_q.bytes[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.busy;
    assign out_last  = st_q.busy && at_end;

    AST_LOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len >= RLW'(3) && len <= RLW'(RB))) else $error("bad reply length"); // R2
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> st_q.idx < st_q.len) else $error("index past end"); // R13
endmodule

// File: rtl/cmdp_top.sv
module cmdp_top
    import cmdp_pkg::*;
#(
    parameter logic [31:0] INIT_SECONDS = 32'd2082844800,
    parameter logic [7:0]  INIT_RATE    = 8'd20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_tick,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        poll_en,
    output logic [7:0]  poll_rate,
    output logic [15:0] dev_mask,
    output logic        pwrdn_req,
    output logic        rst_req
);
    localparam int LW  = $clog2(RX_BYTES + 2);
    localparam int RLW = $clog2(RSP_BYTES + 1);

    logic                       pkt_valid;
    logic [LW-1:0]              pkt_len;
    logic [RX_BYTES-1:0][7:0]   pkt_bytes;
    logic                       rsp_load;
    logic [RLW-1:0]             rsp_len;
    logic [RSP_BYTES-1:0][7:0]  rsp_bytes;

    cmdp_rx #(.N(RX_BYTES), .LW(LW)) u_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .pkt_bytes(pkt_bytes));

    cmdp_exec #(.N(RX_BYTES), .LW(LW), .RB(RSP_BYTES), .RLW(RLW),
                .INIT_SECONDS(INIT_SECONDS), .INIT_RATE(INIT_RATE)) u_exec (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .pkt_valid(pkt_valid),
        .pkt_len(pkt_len), .pkt_bytes(pkt_bytes), .rsp_load(rsp_load),
        .rsp_len(rsp_len), .rsp_bytes(rsp_bytes), .poll_en(poll_en),
        .poll_rate(poll_rate), .dev_mask(dev_mask), .pwrdn_req(pwrdn_req),
        .rst_req(rst_req));

    cmdp_tx #(.RB(RSP_BYTES), .RLW(RLW)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(rsp_load), .len(rsp_len),
        .bytes(rsp_bytes), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last));
endmodule

// File: tb/sim_cmdp_top.sv
module sim_cmdp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        in_last = 1'b0;
    logic        out_valid, out_last, poll_en, pwrdn_req, rst_req;
    logic [7:0]  out_data, poll_rate;
    logic [15:0] dev_mask;

    int tests = 0;
    int fails = 0;
    int pd_cnt = 0;
    int rs_cnt = 0;
    logic [7:0] rsp [16];
    int rsp_n, lat;
    bit gap;

    always #5 clk = ~clk;

    cmdp_top u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .poll_en(poll_en),
        .poll_rate(poll_rate), .dev_mask(dev_mask), .pwrdn_req(pwrdn_req),
        .rst_req(rst_req));

    always @(negedge clk) begin
        if (rst_n && pwrdn_req) pd_cnt <= pd_cnt + 1;
        if (rst_n && rst_req)   rs_cnt <= rs_cnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic send(input int n,
                        input logic [7:0] b0 = 0, input logic [7:0] b1 = 0,
                        input logic [7:0] b2 = 0, input logic [7:0] b3 = 0,
                        input logic [7:0] b4 = 0, input logic [7:0] b5 = 0,
                        input logic [7:0] b6 = 0, input logic [7:0] b7 = 0);
        logic [7:0] b [8];
        b = '{b0, b1, b2, b3, b4, b5, b6, b7};
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = b[i];
            in_last  = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic get_rsp();
        rsp_n = 0;
        lat   = 0;
        gap   = 1'b0;
        for (int w = 1; w <= 12; w++) begin
            @(negedge clk);
            if (out_valid) begin
                lat = w;
                break;
            end
        end
        if (lat == 0) return;
        for (int k = 0; k < 16; k++) begin
            if (!out_valid) begin
                gap = 1'b1;
                break;
            end
            rsp[rsp_n] = out_data;
            rsp_n++;
            if (out_last) break;
            @(negedge clk);
        end
    endtask

    task automatic expect_rsp(input string tag, input int n,
                              input logic [7:0] e0 = 0, input logic [7:0] e1 = 0,
                              input logic [7:0] e2 = 0, input logic [7:0] e3 = 0,
                              input logic [7:0] e4 = 0, input logic [7:0] e5 = 0,
                              input logic [7:0] e6 = 0);
        logic [7:0] e [7];
        e = '{e0, e1, e2, e3, e4, e5, e6};
        get_rsp();
        chk({tag, " length"}, rsp_n, n);
        for (int i = 0; i < n && i < rsp_n; i++)
            chk($sformatf("%s byte%0d", tag, i), rsp[i], e[i]);
    endtask

    task automatic t_reset();
        chk("R1 poll_en", poll_en, 0);
        chk("R1 poll_rate", poll_rate, 20);
        chk("R1 dev_mask", dev_mask, 16'hFFFF);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 requests", {pwrdn_req, rst_req}, 0);
    endtask

    task automatic t_poll_enable();
        send(3, 8'h01, 8'h01, 8'h05);
        expect_rsp("R2 R5 ack", 3, 8'h01, 8'h00, 8'h01);
        chk("R13 latency", lat, 1);
        chk("R13 no gap", gap, 0);
        chk("R5 enabled", poll_en, 1);
        send(3, 8'h01, 8'h01, 8'h00);
        expect_rsp("R5 ack zero", 3, 8'h01, 8'h00, 8'h01);
        chk("R5 disabled", poll_en, 0);
        send(2, 8'h01, 8'h01);
        expect_rsp("R4 poll no arg", 4, 8'h02, 8'h05, 8'h01, 8'h01);
        send(8, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        expect_rsp("R4 overlong", 4, 8'h02, 8'h05, 8'h01, 8'h01);
        chk("R4 overlong no change", poll_en, 0);
    endtask

    task automatic t_rate();
        send(3, 8'h01, 8'h14, 8'h32);
        expect_rsp("R6 ack", 3, 8'h01, 8'h00, 8'h14);
        chk("R6 rate", poll_rate, 8'h32);
        send(3, 8'h01, 8'h14, 8'h00);
        expect_rsp("R6 zero rejected", 4, 8'h02, 8'h05, 8'h01, 8'h14);
        chk("R6 rate kept", poll_rate, 8'h32);
    endtask

    task automatic t_mask();
        send(4, 8'h01, 8'h19, 8'hA5, 8'h3C);
        expect_rsp("R7 ack", 3, 8'h01, 8'h00, 8'h19);
        chk("R7 mask order", dev_mask, 16'hA53C);
        send(3, 8'h01, 8'h19, 8'h11);
        expect_rsp("R7 R4 short", 4, 8'h02, 8'h05, 8'h01, 8'h19);
        chk("R7 mask kept", dev_mask, 16'hA53C);
    endtask

    task automatic t_power();
        send(2, 8'h01, 8'h0A);
        expect_rsp("R8 pwrdn ack", 3, 8'h01, 8'h00, 8'h0A);
        repeat (2) @(negedge clk);
        chk("R8 pwrdn one pulse", pd_cnt, 1);
        send(3, 8'h01, 8'h0A, 8'h00);
        expect_rsp("R8 pwrdn bad", 4, 8'h02, 8'h05, 8'h01, 8'h0A);
        repeat (2) @(negedge clk);
        chk("R8 no pulse on error", pd_cnt, 1);
        send(2, 8'h01, 8'h11);
        expect_rsp("R8 sysrst ack", 3, 8'h01, 8'h00, 8'h11);
        repeat (2) @(negedge clk);
        chk("R8 sysrst one pulse", rs_cnt, 1);
    endtask

    task automatic t_noop();
        send(3, 8'h01, 8'h13, 8'h07);
        expect_rsp("R9 flag ack", 3, 8'h01, 8'h00, 8'h13);
        send(3, 8'h01, 8'h21, 8'h01);
        expect_rsp("R9 msg ack", 3, 8'h01, 8'h00, 8'h21);
        chk("R9 settings", {poll_en, poll_rate, dev_mask}, {1'b0, 8'h32, 16'hA53C});
        send(2, 8'h01, 8'h21);
        expect_rsp("R9 R4 msg short", 4, 8'h02, 8'h05, 8'h01, 8'h21);
    endtask

    task automatic t_unknown();
        send(3, 8'h01, 8'h55, 8'h09);
        expect_rsp("R3 unknown", 4, 8'h02, 8'h02, 8'h01, 8'h55);
    endtask

    task automatic t_clock();
        send(2, 8'h01, 8'h03);
        expect_rsp("R10 reset value", 7, 8'h01, 8'h00, 8'h03, 8'h7C, 8'h25, 8'hB0, 8'h80);
        send(6, 8'h01, 8'h09, 8'h12, 8'h34, 8'h56, 8'h78);
        expect_rsp("R11 write ack", 3, 8'h01, 8'h00, 8'h09);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk) sec_tick = 1'b1;
            @(negedge clk) sec_tick = 1'b0;
        end
        send(2, 8'h01, 8'h03);
        expect_rsp("R10 R11 after ticks", 7, 8'h01, 8'h00, 8'h03, 8'h12, 8'h34, 8'h56, 8'h7B);
        send(5, 8'h01, 8'h09, 8'h01, 8'h02, 8'h03);
        expect_rsp("R11 R4 short", 4, 8'h02, 8'h05, 8'h01, 8'h09);
        send(2, 8'h01, 8'h03);
        expect_rsp("R11 unchanged", 7, 8'h01, 8'h00, 8'h03, 8'h12, 8'h34, 8'h56, 8'h7B);
    endtask

    task automatic t_other_class();
        send(3, 8'h00, 8'h01, 8'h01);
        get_rsp();
        chk("R12 bus class silent", rsp_n, 0);
        chk("R12 poll unchanged", poll_en, 0);
        send(4, 8'h03, 8'h19, 8'h00, 8'h00);
        get_rsp();
        chk("R12 timer class silent", rsp_n, 0);
        chk("R12 mask unchanged", dev_mask, 16'hA53C);
        send(1, 8'h01);
        get_rsp();
        chk("R12 one-byte silent", rsp_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clock();
        t_poll_enable();
        t_rate();
        t_mask();
        t_power();
        t_noop();
        t_unknown();
        t_other_class();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule